// File: doc/BRIEF.md
# Address translation cache with fence

A small fully associative cache of finished virtual-to-physical translations. It sits between a core's address path and the page table walker. A lookup presents a virtual page number, an address-space identifier, an access kind and the current privilege. In the same cycle the block reports either a hit, with the cached physical page number and permission flags, or a miss that asks the walker for a translation. A hit whose permissions do not allow the access reports a fault and does not start a walk.

The walker hands back its result on a fill port. Successful results are written into a slot. Faulting results are dropped. A fence port invalidates either every slot or only the slots tagged with one identifier. Software raises a full fence whenever it changes the root table pointer, so that no later lookup can reach a translation from the old table.

Top module: `xlat_cache`

## Requirements
- R1: After reset no slot is valid. Every lookup misses and raises `walk_req_o`.
- R2: A lookup that matches the page number and identifier of a valid slot asserts `lkp_hit_o` in the same cycle. It returns that slot's physical page number and flags, and `walk_req_o` stays low.
- R3: A lookup with no matching valid slot, including a matching page number under another identifier, raises `walk_req_o`. `lkp_hit_o` and `lkp_fault_o` stay low.
- R4: A non-faulting fill is visible to lookups from the next cycle on. A fill whose page number and identifier already sit in a valid slot overwrites that slot.
- R5: A new fill goes to the lowest-numbered invalid slot. When all slots are valid it evicts the slot named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, on each such eviction only.
- R6: A fill flagged as a fault installs nothing and leaves every slot unchanged.
- R7: A fence with `fence_all_i` high invalidates every slot.
- R8: A fence with `fence_all_i` low invalidates only the slots whose identifier equals `fence_asid_i`. Other slots stay valid.
- R9: When a fence and a fill arrive in the same cycle, the fence is applied and the fill is discarded.
- R10: Flags are encoded as bit0 read, bit1 write, bit2 execute, bit3 user. Access kind 0 (load) needs read, 1 (store) needs write, 2 (fetch) needs execute, and 3 always faults. User mode (`lkp_user_i`=1) needs the user bit set. Supervisor mode needs it clear. A hit that breaks any of these rules raises `lkp_fault_o` and leaves `walk_req_o` low.
- R11: At most one slot matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Virtual page number to translate |
| lkp_asid_i | input | ASID_W | Address-space identifier of the lookup |
| lkp_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lkp_user_i | input | 1 | 1 for user mode, 0 for supervisor |
| lkp_hit_o | output | 1 | Translation found |
| lkp_ppn_o | output | PPN_W | Physical page number on a hit, zero otherwise |
| lkp_perm_o | output | 4 | Cached flags on a hit |
| lkp_fault_o | output | 1 | Hit that the permission rules forbid |
| walk_req_o | output | 1 | Miss; the walker must translate |
| fill_valid_i | input | 1 | Walker result present |
| fill_vpn_i | input | VPN_W | Page number of the result |
| fill_asid_i | input | ASID_W | Identifier of the result |
| fill_ppn_i | input | PPN_W | Physical page number of the result |
| fill_perm_i | input | 4 | Leaf flags of the result |
| fill_fault_i | input | 1 | Walk ended in a fault |
| fence_valid_i | input | 1 | Fence command |
| fence_all_i | input | 1 | 1 invalidates all slots, 0 only those of fence_asid_i |
| fence_asid_i | input | ASID_W | Identifier to invalidate |

## Verification
The bench fills every slot with distinct page numbers under alternating identifiers. It then probes each page under both identifiers, which tells a true tag match from a page-number-only match. Further fills beyond capacity, before and after an identifier fence, show whether the victim comes from the free-slot search or from the round-robin pointer. Each eviction is visible as exactly one page turning into a miss. The permission rules are swept over all sixteen flag values against every access kind in both privileges. Faulting fills and a fence that collides with a fill are followed by probes of pages that must, or must not, still hit.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic u;
    logic x;
    logic w;
    logic r;
  } perm_t;
endpackage

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match #(
  parameter int N_ENTRY = 8,
  parameter int VPN_W   = 27,
  parameter int ASID_W  = 16
) (
  input  logic [N_ENTRY-1:0]             valid_i,
  input  logic [N_ENTRY-1:0][VPN_W-1:0]  vpn_i,
  input  logic [N_ENTRY-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]               key_vpn_i,
  input  logic [ASID_W-1:0]              key_asid_i,
  output logic [N_ENTRY-1:0]             match_o
);
  for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim #(
  parameter int N_ENTRY = 8,
  localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic [N_ENTRY-1:0] valid_i,
  input  logic [N_ENTRY-1:0] match_i,
  input  logic [IDX_W-1:0]   ptr_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               evict_o
);
  logic [IDX_W-1:0] idx_match, idx_free;
  logic any_match, any_free;

  always_comb begin
    idx_match = '0;
    idx_free  = '0;
    // descending scan: the lowest index is written last and wins
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (match_i[i])  idx_match = IDX_W'(i);
      if (!valid_i[i]) idx_free  = IDX_W'(i);
    end
    any_match = |match_i;
    any_free  = ~&valid_i;
    evict_o   = !any_match && !any_free;
    if (any_match)     idx_o = idx_match;
    else if (any_free) idx_o = idx_free;
    else               idx_o = ptr_i;
  end
endmodule

// File: rtl/xlat_perm.sv
`timescale 1ns/1ps
module xlat_perm
  import xlat_pkg::*;
(
  input  perm_t perm_i,
  input  acc_e  acc_i,
  input  logic  user_i,
  output logic  allow_o
);
  logic kind_ok;

  always_comb begin
    unique case (acc_i)
      ACC_LOAD:  kind_ok = perm_i.r;
      ACC_STORE: kind_ok = perm_i.w;
      ACC_FETCH: kind_ok = perm_i.x;
      default:   kind_ok = 1'b0;
    endcase
    // user mode needs U set; supervisor must not touch U pages
    allow_o = kind_ok && (perm_i.u == user_i);
  end
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int N_ENTRY = 8,
  parameter int VPN_W   = 27,
  parameter int PPN_W   = 44,
  parameter int ASID_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  input  logic [1:0]        lkp_acc_i,
  input  logic              lkp_user_i,
  output logic              lkp_hit_o,
  output logic [PPN_W-1:0]  lkp_ppn_o,
  output logic [3:0]        lkp_perm_o,
  output logic              lkp_fault_o,
  output logic              walk_req_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [3:0]        fill_perm_i,
  input  logic              fill_fault_i,
  input  logic              fence_valid_i,
  input  logic              fence_all_i,
  input  logic [ASID_W-1:0] fence_asid_i
);
  localparam int IDX_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRY - 1);

  logic [N_ENTRY-1:0]             valid_q;
  logic [N_ENTRY-1:0][VPN_W-1:0]  vpn_q;
  logic [N_ENTRY-1:0][ASID_W-1:0] asid_q;
  logic [N_ENTRY-1:0][PPN_W-1:0]  ppn_q;
  logic [N_ENTRY-1:0][3:0]        perm_q;
  logic [IDX_W-1:0]               ptr_q;

  logic [N_ENTRY-1:0] lkp_match, fill_match;
  logic [IDX_W-1:0]   fill_idx;
  logic               fill_evict, fill_take, allow;
  logic [PPN_W-1:0]   hit_ppn;
  logic [3:0]         hit_perm;

  xlat_match #(.N_ENTRY(N_ENTRY), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lkp_match (
    .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(lkp_vpn_i), .key_asid_i(lkp_asid_i), .match_o(lkp_match)
  );

  xlat_match #(.N_ENTRY(N_ENTRY), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
    .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(fill_vpn_i), .key_asid_i(fill_asid_i), .match_o(fill_match)
  );

  xlat_victim #(.N_ENTRY(N_ENTRY)) u_victim (
    .valid_i(valid_q), .match_i(fill_match), .ptr_i(ptr_q),
    .idx_o(fill_idx), .evict_o(fill_evict)
  );

  // one-hot read mux
  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    for (int i = 0; i < N_ENTRY; i++) begin
      if (lkp_match[i]) begin
        hit_ppn  = hit_ppn | ppn_q[i];
        hit_perm = hit_perm | perm_q[i];
      end
    end
  end

  xlat_perm u_perm (
    .perm_i(perm_t'(hit_perm)), .acc_i(acc_e'(lkp_acc_i)),
    .user_i(lkp_user_i), .allow_o(allow)
  );

  assign lkp_hit_o   = lkp_valid_i && (|lkp_match);
  assign lkp_ppn_o   = lkp_hit_o ? hit_ppn : '0;
  assign lkp_perm_o  = lkp_hit_o ? hit_perm : '0;
  assign lkp_fault_o = lkp_hit_o && !allow;
  assign walk_req_o  = lkp_valid_i && !(|lkp_match);

  // fence wins over a same-cycle fill
  assign fill_take = fill_valid_i && !fill_fault_i && !fence_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      vpn_q   <= '0;
      asid_q  <= '0;
      ppn_q   <= '0;
      perm_q  <= '0;
      ptr_q   <= '0;
    end else begin
      if (fence_valid_i) begin
        for (int i = 0; i < N_ENTRY; i++)
          if (fence_all_i || asid_q[i] == fence_asid_i) valid_q[i] <= 1'b0;
      end else if (fill_take) begin
        valid_q[fill_idx] <= 1'b1;
        vpn_q[fill_idx]   <= fill_vpn_i;
        asid_q[fill_idx]  <= fill_asid_i;
        ppn_q[fill_idx]   <= fill_ppn_i;
        perm_q[fill_idx]  <= fill_perm_i;
        if (fill_evict) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  AST_EMPTY_MISSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q == '0 && lkp_valid_i) |-> (walk_req_o && !lkp_hit_o)); // R1
  AST_MISS_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && !lkp_hit_o) |-> (walk_req_o && !lkp_fault_o)); // R3
  AST_FAULT_NO_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_fault_o |-> (lkp_hit_o && !walk_req_o)); // R10
  AST_ONE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_match)); // R11
  AST_BAD_FILL_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_fault_i && !fence_valid_i) |=> $stable(valid_q)); // R6
  AST_FENCE_ALL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_valid_i && fence_all_i) |=> (valid_q == '0)); // R7
  AST_FENCE_BEATS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_valid_i && fill_valid_i) |=> ((valid_q & ~$past(valid_q)) == '0)); // R9

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ast
    AST_FENCE_ASID_HITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fence_valid_i && !fence_all_i && valid_q[g] && asid_q[g] == fence_asid_i)
        |=> !valid_q[g]); // R8
    AST_FENCE_ASID_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fence_valid_i && !fence_all_i && valid_q[g] && asid_q[g] != fence_asid_i)
        |=> valid_q[g]); // R8
  end
endmodule

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  localparam int VPN_W = 27, PPN_W = 44, ASID_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lkp_valid = 0, lkp_user = 0;
  logic [VPN_W-1:0] lkp_vpn = '0;
  logic [ASID_W-1:0] lkp_asid = '0;
  logic [1:0] lkp_acc = '0;
  logic lkp_hit, lkp_fault, walk_req;
  logic [PPN_W-1:0] lkp_ppn;
  logic [3:0] lkp_perm;
  logic fill_valid = 0, fill_fault = 0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [3:0] fill_perm = '0;
  logic fence_valid = 0, fence_all = 0;
  logic [ASID_W-1:0] fence_asid = '0;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xlat_cache u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_vpn_i(lkp_vpn), .lkp_asid_i(lkp_asid),
    .lkp_acc_i(lkp_acc), .lkp_user_i(lkp_user),
    .lkp_hit_o(lkp_hit), .lkp_ppn_o(lkp_ppn), .lkp_perm_o(lkp_perm),
    .lkp_fault_o(lkp_fault), .walk_req_o(walk_req),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_ppn_i(fill_ppn), .fill_perm_i(fill_perm), .fill_fault_i(fill_fault),
    .fence_valid_i(fence_valid), .fence_all_i(fence_all), .fence_asid_i(fence_asid)
  );

  function automatic logic [PPN_W-1:0] ppn_of(int v);
    return 44'h0_0008_0000 + PPN_W'(v * 3);
  endfunction

  function automatic int asid_of(int v);
    return v % 2;
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic fill(int v, logic [3:0] p, logic flt, logic fence, logic all, int fa);
    @(negedge clk);
    fill_valid = 1; fill_vpn = VPN_W'(v); fill_asid = ASID_W'(asid_of(v));
    fill_ppn = ppn_of(v); fill_perm = p; fill_fault = flt;
    fence_valid = fence; fence_all = all; fence_asid = ASID_W'(fa);
    @(negedge clk);
    fill_valid = 0; fill_fault = 0; fence_valid = 0; fence_all = 0;
  endtask

  task automatic fence_cmd(logic all, int fa);
    @(negedge clk);
    fence_valid = 1; fence_all = all; fence_asid = ASID_W'(fa);
    @(negedge clk);
    fence_valid = 0; fence_all = 0;
  endtask

  task automatic look(int v, int a, logic [1:0] acc, logic usr, bit e_hit,
                      logic [3:0] e_perm, bit e_flt, string req);
    logic [PPN_W-1:0] e_ppn;
    @(negedge clk);
    lkp_valid = 1; lkp_vpn = VPN_W'(v); lkp_asid = ASID_W'(a);
    lkp_acc = acc; lkp_user = usr;
    #1;
    e_ppn = e_hit ? ppn_of(v) : '0;
    vectors++;
    if (lkp_hit !== e_hit || walk_req !== !e_hit || lkp_fault !== e_flt ||
        lkp_ppn !== e_ppn || (e_hit && lkp_perm !== e_perm)) begin
      miscompares++;
      $display("FAIL %s vpn=%0d asid=%0d: hit/walk/fault/ppn/perm = %b/%b/%b/%h/%h expected %b/%b/%b/%h/%h",
               req, v, a, lkp_hit, walk_req, lkp_fault, lkp_ppn, lkp_perm,
               e_hit, !e_hit, e_flt, e_ppn, e_perm);
    end
  endtask

  // RW supervisor page: load by supervisor allowed
  localparam logic [3:0] P_RW = 4'b0011;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    for (int v = 0; v < 4; v++) look(v, asid_of(v), 2'd0, 0, 0, '0, 0, "R1");

    // R4/R2: fill all slots, probe under own and foreign identifier (R3)
    for (int v = 0; v < 8; v++) fill(v, P_RW, 0, 0, 0, 0);
    for (int v = 0; v < 8; v++) begin
      look(v, asid_of(v), 2'd0, 0, 1, P_RW, 0, "R2");
      look(v, 1 - asid_of(v), 2'd0, 0, 0, '0, 0, "R3");
    end

    // R5: full, pointer evicts slot 0 then slot 1
    fill(8, P_RW, 0, 0, 0, 0);
    look(0, 0, 2'd0, 0, 0, '0, 0, "R5");
    look(8, 0, 2'd0, 0, 1, P_RW, 0, "R4");
    look(1, 1, 2'd0, 0, 1, P_RW, 0, "R5");
    fill(9, P_RW, 0, 0, 0, 0);
    look(1, 1, 2'd0, 0, 0, '0, 0, "R5");
    look(9, 1, 2'd0, 0, 1, P_RW, 0, "R4");

    // R8: fence identifier 1 drops odd pages only
    fence_cmd(0, 1);
    for (int v = 2; v < 10; v++)
      look(v, asid_of(v), 2'd0, 0, (asid_of(v) == 0), P_RW, 0, "R8");

    // R5: free slots 1,3,5,7 taken first, then pointer (at 2) evicts page 2
    for (int v = 20; v < 24; v++) fill(v, P_RW, 0, 0, 0, 0);
    look(2, 0, 2'd0, 0, 1, P_RW, 0, "R5");
    fill(24, P_RW, 0, 0, 0, 0);
    look(2, 0, 2'd0, 0, 0, '0, 0, "R5");
    for (int v = 20; v < 25; v++) look(v, asid_of(v), 2'd0, 0, 1, P_RW, 0, "R5");
    look(4, 0, 2'd0, 0, 1, P_RW, 0, "R5");

    // R6: faulting walk result installs nothing, evicts nothing
    fill(30, P_RW, 1, 0, 0, 0);
    look(30, 0, 2'd0, 0, 0, '0, 0, "R6");
    look(4, 0, 2'd0, 0, 1, P_RW, 0, "R6");
    look(6, 0, 2'd0, 0, 1, P_RW, 0, "R6");
    look(8, 0, 2'd0, 0, 1, P_RW, 0, "R6");

    // R9 + R7: full fence with a colliding fill (root pointer change)
    fill(31, P_RW, 0, 1, 1, 0);
    look(31, 1, 2'd0, 0, 0, '0, 0, "R9");
    for (int v = 20; v < 25; v++) look(v, asid_of(v), 2'd0, 0, 0, '0, 0, "R7");
    look(4, 0, 2'd0, 0, 0, '0, 0, "R7");

    // R4 overwrite + R10 sweep over all flag values, kinds and privileges
    for (int f = 0; f < 16; f++) begin
      fill(40, 4'(f), 0, 0, 0, 0);
      for (int acc = 0; acc < 4; acc++) begin
        for (int usr = 0; usr < 2; usr++) begin
          bit need;
          case (acc)
            0: need = f[0];
            1: need = f[1];
            2: need = f[2];
            default: need = 0;
          endcase
          look(40, 0, 2'(acc), 1'(usr), 1, 4'(f), !need || (usr != f[3]), "R10");
        end
      end
    end
    look(40, 1, 2'd0, 0, 0, '0, 0, "R3");

    // R8: identifier fence that spares the other identifier
    fill(41, P_RW, 0, 0, 0, 0);
    fence_cmd(0, 0);
    look(40, 0, 2'd0, 0, 0, '0, 0, "R8");
    look(41, 1, 2'd0, 0, 1, P_RW, 0, "R8");

    @(negedge clk);
    lkp_valid = 0;
    done = 1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish");
      report();
    end
  end
endmodule